// File: doc/BRIEF.md
# Open-Row DRAM Access Controller

This block turns word requests from a processor-side port into strobe sequences for a DRAM array built as a grid of multi-bit supercells. Each request address is split into a row index (upper bits) and a column index (lower bits). Both indices go out one after the other on a single narrow address bus. A row strobe copies the selected row into the array's internal row buffer. A column strobe then reads one supercell out of that buffer or writes one into it.

The controller keeps the last opened row active. A request that falls in that row goes straight to the column strobe. A request to any other row first closes the active row with a close strobe, which writes the row buffer back to the array, and then opens the new row. Writes change only the buffered copy until the row is closed. Requests use a valid/ready handshake, and read data comes back with a single-cycle response pulse.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset, `req_ready_o` is 1, and `dram_ras_o`, `dram_cas_o`, `dram_pre_o` and `rsp_valid_o` are all 0.
- R2: After reset no row is open, so the first request issues a row strobe in one cycle and a column strobe in the next, with no close strobe.
- R3: A request whose row equals the open row issues only a column strobe, with no row or close strobe.
- R4: A request to a row other than the open row issues a close strobe, a row strobe and a column strobe in three consecutive cycles.
- R5: A read returns the addressed supercell on `rsp_rdata_o`. `rsp_valid_o` is high for exactly the one cycle that follows its column strobe.
- R6: A write asserts `dram_we_o` together with its column strobe and produces no response pulse. A later read of that address returns the written value, both while the row stays open and after the row has been closed and reopened.
- R7: `req_ready_o` is 0 in every cycle that carries a strobe or a response, and at most one of the row, column and close strobes is high in any cycle.
- R8: During a row strobe `dram_addr_o` carries the upper `log2(ROWS)` bits of the request address. During a column strobe it carries the lower `log2(COLS)` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Supercell address, {row, column} |
| req_wdata_i | input | WIDTH | Write data |
| rsp_valid_o | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata_o | output | WIDTH | Read data |
| dram_addr_o | output | PW | Shared row/column index bus |
| dram_ras_o | output | 1 | Row strobe: load row into buffer |
| dram_cas_o | output | 1 | Column strobe: access supercell in buffer |
| dram_pre_o | output | 1 | Close strobe: write buffer back to array |
| dram_we_o | output | 1 | Column access is a write |
| dram_wdata_o | output | WIDTH | Supercell write data |
| dram_rdata_i | input | WIDTH | Supercell read data, valid the cycle after the column strobe |

## Verification
The bench builds the block with its default 4-row by 4-column grid of 8-bit supercells and attaches a behavioural array model that has its own row buffer. With only four rows, a short directed stream visits every kind of access: a first open from the closed state, a same-row hit, a row change that writes data back, and a sweep over all sixteen supercells. Because the array is small, a value written to one row can be followed through closing that row, opening another and reopening the first, which shows that the write-back really took place.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_RAS,
    ST_CAS,
    ST_RESP
  } seq_state_e;
endpackage

// File: rtl/dram_open_row.sv
module dram_open_row #(
  parameter int unsigned RB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [RB-1:0] row_i,
  input  logic [RB-1:0] probe_row_i,
  output logic [RB-1:0] open_row_o,
  output logic          open_valid_o,
  output logic          hit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_row_o   <= '0;
      open_valid_o <= 1'b0;
    end else if (load_i) begin
      open_row_o   <= row_i;
      open_valid_o <= 1'b1;
    end
  end

  assign hit_o = open_valid_o && (open_row_o == probe_row_i);
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_we_i,
  input  logic hit_i,
  input  logic open_valid_i,
  input  logic lat_we_i,
  output logic accept_o,
  output logic ready_o,
  output logic ras_o,
  output logic cas_o,
  output logic pre_o,
  output logic rsp_valid_o
);
  seq_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign ready_o     = (state_q == ST_IDLE);
  assign accept_o    = ready_o && req_valid_i;
  assign pre_o       = (state_q == ST_PRE);
  assign ras_o       = (state_q == ST_RAS);
  assign cas_o       = (state_q == ST_CAS);
  assign rsp_valid_o = (state_q == ST_RESP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        if (hit_i)             state_d = ST_CAS;
        else if (open_valid_i) state_d = ST_PRE;
        else                   state_d = ST_RAS;
      end
      ST_PRE:  state_d = ST_RAS;
      ST_RAS:  state_d = ST_CAS;
      ST_CAS:  state_d = lat_we_i ? ST_IDLE : ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // req_we_i is taken by the top's request latch; kept here for a uniform port set
  logic unused_we;
  assign unused_we = req_we_i;
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl #(
  parameter int unsigned ROWS  = 4,
  parameter int unsigned COLS  = 4,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned RB = $clog2(ROWS),
  localparam int unsigned CB = $clog2(COLS),
  localparam int unsigned AW = RB + CB,
  localparam int unsigned PW = (RB > CB) ? RB : CB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_we_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [WIDTH-1:0] req_wdata_i,
  output logic             rsp_valid_o,
  output logic [WIDTH-1:0] rsp_rdata_o,
  output logic [PW-1:0]    dram_addr_o,
  output logic             dram_ras_o,
  output logic             dram_cas_o,
  output logic             dram_pre_o,
  output logic             dram_we_o,
  output logic [WIDTH-1:0] dram_wdata_o,
  input  logic [WIDTH-1:0] dram_rdata_i
);
  logic          accept;
  logic          hit, open_valid;
  logic [RB-1:0] open_row;
  logic [AW-1:0] lat_addr;
  logic          lat_we;
  logic [WIDTH-1:0] lat_wdata;
  logic [RB-1:0] lat_row;
  logic [CB-1:0] lat_col;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_addr  <= '0;
      lat_we    <= 1'b0;
      lat_wdata <= '0;
    end else if (accept) begin
      lat_addr  <= req_addr_i;
      lat_we    <= req_we_i;
      lat_wdata <= req_wdata_i;
    end
  end

  assign lat_row = lat_addr[AW-1:CB];
  assign lat_col = lat_addr[CB-1:0];

  dram_open_row #(.RB(RB)) u_open_row (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (dram_ras_o),
    .row_i       (lat_row),
    .probe_row_i (req_addr_i[AW-1:CB]),
    .open_row_o  (open_row),
    .open_valid_o(open_valid),
    .hit_o       (hit)
  );

  dram_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .hit_i       (hit),
    .open_valid_i(open_valid),
    .lat_we_i    (lat_we),
    .accept_o    (accept),
    .ready_o     (req_ready_o),
    .ras_o       (dram_ras_o),
    .cas_o       (dram_cas_o),
    .pre_o       (dram_pre_o),
    .rsp_valid_o (rsp_valid_o)
  );

  // shared index bus: row during open/close, column during access
  always_comb begin
    dram_addr_o = '0;
    if (dram_ras_o)      dram_addr_o = PW'(lat_row);
    else if (dram_pre_o) dram_addr_o = PW'(open_row);
    else if (dram_cas_o) dram_addr_o = PW'(lat_col);
  end

  assign dram_we_o    = dram_cas_o && lat_we;
  assign dram_wdata_o = lat_wdata;
  assign rsp_rdata_o  = rsp_valid_o ? dram_rdata_i : '0;
endmodule

// File: rtl/dram_page_ctrl_chk.sv
module dram_page_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic dram_ras_o,
  input logic dram_cas_o,
  input logic dram_pre_o,
  input logic dram_we_o,
  input logic rsp_valid_o
);
  AST_STROBE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dram_ras_o, dram_cas_o, dram_pre_o})); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dram_ras_o || dram_cas_o || dram_pre_o || rsp_valid_o) |-> !req_ready_o); // R7
  AST_RAS_THEN_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_ras_o |=> dram_cas_o); // R2
  AST_PRE_THEN_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_pre_o |=> dram_ras_o); // R4
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R5
  AST_READ_GETS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dram_cas_o && !dram_we_o) |=> rsp_valid_o); // R5
  AST_WRITE_NO_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_we_o |=> !rsp_valid_o); // R6
endmodule

bind dram_page_ctrl dram_page_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .dram_ras_o (dram_ras_o),
  .dram_cas_o (dram_cas_o),
  .dram_pre_o (dram_pre_o),
  .dram_we_o  (dram_we_o),
  .rsp_valid_o(rsp_valid_o)
);

// File: tb/dram_array_model.sv
module dram_array_model #(
  parameter int unsigned ROWS  = 4,
  parameter int unsigned COLS  = 4,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned RB = $clog2(ROWS),
  localparam int unsigned CB = $clog2(COLS),
  localparam int unsigned PW = (RB > CB) ? RB : CB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PW-1:0]    addr_i,
  input  logic             ras_i,
  input  logic             cas_i,
  input  logic             pre_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] cells  [ROWS*COLS];
  logic [WIDTH-1:0] rowbuf [COLS];
  logic [RB-1:0]    cur_row;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ROWS*COLS; i++) cells[i] <= WIDTH'(i * 37 + 5);
      for (int c = 0; c < COLS; c++) rowbuf[c] <= '0;
      cur_row <= '0;
      rdata_o <= '0;
    end else begin
      if (ras_i) begin
        cur_row <= addr_i[RB-1:0];
        for (int c = 0; c < COLS; c++)
          rowbuf[c] <= cells[int'(addr_i[RB-1:0]) * COLS + c];
      end
      if (pre_i)
        for (int c = 0; c < COLS; c++)
          cells[int'(cur_row) * COLS + c] <= rowbuf[c];
      if (cas_i && we_i)  rowbuf[addr_i[CB-1:0]] <= wdata_i;
      if (cas_i && !we_i) rdata_o <= rowbuf[addr_i[CB-1:0]];
    end
  end
endmodule

// File: tb/dram_page_ctrl_bench.sv
`timescale 1ns/1ps
module dram_page_ctrl_bench;
  localparam int ROWS = 4, COLS = 4, WIDTH = 8;
  localparam int RB = $clog2(ROWS), CB = $clog2(COLS);
  localparam int AW = RB + CB;
  localparam int PW = (RB > CB) ? RB : CB;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [WIDTH-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, ras, cas, pre, dwe;
  logic [WIDTH-1:0] rsp_rdata, dwdata, drdata;
  logic [PW-1:0] daddr;

  dram_page_ctrl #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) u_dram_page_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .dram_addr_o(daddr), .dram_ras_o(ras), .dram_cas_o(cas), .dram_pre_o(pre),
    .dram_we_o(dwe), .dram_wdata_o(dwdata), .dram_rdata_i(drdata)
  );

  dram_array_model #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) u_array (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(daddr), .ras_i(ras), .cas_i(cas),
    .pre_i(pre), .we_i(dwe), .wdata_i(dwdata), .rdata_o(drdata)
  );

  int checks = 0, errors = 0;
  logic [WIDTH-1:0] refm [ROWS*COLS];
  bit      have_open = 1'b0;
  int      open_row = 0;

  task automatic chk(input bit ok, input string tag, input string detail);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", tag, detail);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // issue one request, record strobe order and check it against the open-row model
  task automatic run_req(input bit we, input int addr, input logic [WIDTH-1:0] wd);
    string seq = "", exp_seq;
    string seq_tag;
    int row = addr / COLS, col = addr % COLS;
    logic [WIDTH-1:0] got = '0;
    bit ready_bad = 1'b0, pins_bad = 1'b0, multi = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = AW'(addr); req_wdata = wd;
    @(posedge clk);
    while (!req_ready) @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n < 12; n++) begin
      if (int'(ras) + int'(cas) + int'(pre) > 1) multi = 1'b1;
      if ((ras || cas || pre || rsp_valid) && req_ready) ready_bad = 1'b1;
      if (pre) seq = {seq, "P"};
      if (ras) begin
        seq = {seq, "R"};
        if (int'(daddr) != row) pins_bad = 1'b1;
      end
      if (cas) begin
        seq = {seq, dwe ? "W" : "C"};
        if (int'(daddr) != col) pins_bad = 1'b1;
      end
      if (rsp_valid) begin
        seq = {seq, "D"};
        got = rsp_rdata;
      end
      if (req_ready) break;
      @(negedge clk);
    end
    if (have_open && open_row == row) begin exp_seq = ""; seq_tag = "R3"; end
    else if (have_open) begin exp_seq = "PR"; seq_tag = "R4"; end
    else begin exp_seq = "R"; seq_tag = "R2"; end
    exp_seq = {exp_seq, we ? "W" : "CD"};
    have_open = 1'b1; open_row = row;
    chk(seq == exp_seq, seq_tag, $sformatf("addr %0d strobes act=%s exp=%s", addr, seq, exp_seq));
    chk(!ready_bad && !multi, "R7", $sformatf("addr %0d busy_ready act=%0b multi act=%0b exp=0", addr, ready_bad, multi));
    chk(!pins_bad, "R8", $sformatf("addr %0d pin mismatch act=1 exp=0", addr));
    if (we) refm[addr] = wd;
    else chk(got == refm[addr], "R5", $sformatf("addr %0d data act=%0h exp=%0h", addr, got, refm[addr]));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready && !ras && !cas && !pre && !rsp_valid, "R1",
        $sformatf("reset act=%0b%0b%0b%0b%0b exp=10000", req_ready, ras, cas, pre, rsp_valid));
  endtask

  task automatic t_first_open();  // R2
    run_req(1'b0, 1*COLS + 2, '0);
  endtask

  task automatic t_row_hit();  // R3
    run_req(1'b0, 1*COLS + 3, '0);
    run_req(1'b0, 1*COLS + 1, '0);
  endtask

  task automatic t_write_open_row();  // R6 buffered write read back
    run_req(1'b1, 1*COLS + 0, 8'hA5);
    run_req(1'b0, 1*COLS + 0, '0);
  endtask

  task automatic t_writeback();  // R4, R6 value survives close and reopen
    run_req(1'b1, 1*COLS + 3, 8'h3C);
    run_req(1'b0, 3*COLS + 1, '0);
    run_req(1'b0, 1*COLS + 3, '0);
    run_req(1'b0, 1*COLS + 0, '0);
  endtask

  task automatic t_sweep();  // R5, R8 every supercell
    for (int a = 0; a < ROWS*COLS; a++) run_req(1'b0, a, '0);
    for (int a = ROWS*COLS - 1; a >= 0; a--) run_req(1'b1, a, WIDTH'(a * 11 + 1));
    for (int a = 0; a < ROWS*COLS; a++) run_req(1'b0, a, '0);
  endtask

  initial begin
    for (int i = 0; i < ROWS*COLS; i++) refm[i] = WIDTH'(i * 37 + 5);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    t_reset();
    t_first_open();
    t_row_hit();
    t_write_open_row();
    t_writeback();
    t_sweep();
    repeat (4) @(negedge clk);
    chk(!rsp_valid && req_ready, "R6", $sformatf("idle after writes act=%0b%0b exp=01", rsp_valid, req_ready));
    finish_run();
  end
endmodule